// File: doc/BRIEF.md
# Switch Port-Group Forwarding Resolver

This block chooses the egress ports for every frame that enters an Ethernet switch with twelve front-panel ports and one CPU port. It holds a writable table of 13-bit port-group masks, where bit 12 is the CPU port. For each frame it is given the ingress port, the outcome of the MAC-table search (hit flag, entry type, destination index) and the frame's flood class. It returns a registered verdict one cycle later. The verdict is the egress port mask together with a flag that says the CPU received the frame through the copy path.

The forwarded set is the bitwise AND of three masks. The first is the destination group, which a MAC-table hit selects, or which a per-class flood pointer selects on a miss. The second is an aggregation group, which is fixed to all ones here. The third is the source group stored for the ingress port. The CPU port is treated differently. A hit whose entry type is 0 or 1 and whose destination group contains the CPU bit delivers the frame to the CPU even when the source group excludes it. Flooded frames never take this path. Software keeps the table and the three flood pointers up to date through a one-cycle write strobe.

Top module: `pgroup_fwd_resolver`

## Requirements
- R1: A cycle with `frm_valid` high produces `out_valid` high on the next clock edge. A cycle with `frm_valid` low produces `out_valid` low on the next edge.
- R2: For a front-panel ingress port, `out_egress` bits 0..11 equal (destination group AND source group), with the ingress port's own bit removed. The aggregation group is all ones.
- R3: On a hit (`frm_hit`=1) the destination group is table entry `frm_dest_idx` when that index is 0..63. An index of 64 or more gives an empty destination group.
- R4: On a miss the destination group is the table entry named by the flood pointer of the frame's class: 0 = unknown unicast, 1 = multicast, 2 = broadcast. Class 3 gives an empty group. A pointer value of 92 or more also gives an empty group.
- R5: The source group is table entry 80 + `frm_src_port`. An ingress port value of 12 or more gives an empty source group.
- R6: The ingress port's own bit is never set in `out_egress`.
- R7: When the frame is a hit with `frm_etype` 0 or 1 and bit 12 is set in the destination group, `out_cpu_copy` is 1 and `out_egress` bit 12 is 1, whatever the source group holds.
- R8: In every other case `out_cpu_copy` is 0, and `out_egress` bit 12 equals destination bit 12 AND source bit 12. This covers misses and hits of type 2 or 3.
- R9: After reset, entries 0..11 hold only their own port bit. Entry 59 holds only bit 12. Entries 60, 61 and 62 hold all front-panel bits. Entry 80+i holds all front-panel bits except bit i. Every other entry is zero. The flood pointers reset to unicast 60, multicast 61 and broadcast 62.
- R10: A table write to an address in 0..63 or 80..91 replaces that entry. A write to 64..79 or to 92 and above changes nothing, and those entries always read as zero.
- R11: A pointer write with class 0..2 replaces that class's flood pointer, and a write with class 3 is ignored. A write of either kind in the same cycle as a frame takes effect from the following frame on.
- R12: While `out_valid` is low, `out_egress` and `out_cpu_copy` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 7 | Table entry to write |
| tbl_wr_data | input | 13 | New mask value, bit 12 = CPU |
| ptr_wr_en | input | 1 | Flood pointer write strobe |
| ptr_wr_cls | input | 2 | Flood class to retarget (0 uc, 1 mc, 2 bc) |
| ptr_wr_idx | input | 7 | New table index for that class |
| frm_valid | input | 1 | Frame descriptor present this cycle |
| frm_src_port | input | 4 | Ingress port |
| frm_hit | input | 1 | MAC-table search found an entry |
| frm_etype | input | 2 | Type of the matching entry |
| frm_dest_idx | input | 7 | Destination index from the matching entry |
| frm_cls | input | 2 | Flood class (0 uc, 1 mc, 2 bc, 3 none) |
| out_valid | output | 1 | Verdict present |
| out_egress | output | 13 | Final egress ports, bit 12 = CPU |
| out_cpu_copy | output | 1 | CPU reached through the copy path |

## Verification
The clocked checks assume that the frame descriptor fields are stable and defined in any cycle where `frm_valid` is high. The own-bit check also assumes that its ingress port lies in the front-panel range when it is applied, so the check is guarded on that range. The bench drives every field from its negative-edge tasks, holds `frm_valid` low through reset and between frames, and drives ingress port 12 only to exercise the empty-source-group case, which the guard excludes. Writes and frames share a cycle only in the dedicated same-cycle sequence, where the bench expects the table contents from before the write.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    localparam int unsigned NPORT      = 12;
    localparam int unsigned CPU_BIT    = NPORT;
    localparam int unsigned MASK_W     = NPORT + 1;
    localparam int unsigned TBL_DEPTH  = 92;
    localparam int unsigned MC_LAST    = 63;
    localparam int unsigned RSV_FIRST  = MC_LAST + 1;
    localparam int unsigned SRC_BASE   = 80;
    localparam int unsigned IDX_W      = $clog2(TBL_DEPTH);
    localparam int unsigned PORT_W     = $clog2(MASK_W);
    localparam int unsigned NCLS       = 3;
    localparam int unsigned CPU_ONLY_E = 59;
    localparam int unsigned FLOOD_UC_E = 60;

    typedef logic [MASK_W-1:0] pmask_t;
    typedef logic [IDX_W-1:0]  tidx_t;
    typedef logic [PORT_W-1:0] port_t;

    typedef enum logic [1:0] {
        FC_UC   = 2'd0,
        FC_MC   = 2'd1,
        FC_BC   = 2'd2,
        FC_NONE = 2'd3
    } fclass_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] etype;
        tidx_t      dest;
        fclass_t    cls;
        port_t      src;
    } frame_t;

    typedef struct packed {
        pmask_t egress;
        logic   cpu_copy;
    } verdict_t;

    localparam pmask_t FRONT_ALL = pmask_t'((1 << NPORT) - 1);
    localparam pmask_t AGG_ALL   = '1;

    function automatic pmask_t reset_entry(int unsigned i);
        pmask_t m;
        m = '0;
        if (i < NPORT)
            m = pmask_t'(1) << i;
        else if (i == CPU_ONLY_E)
            m = pmask_t'(1) << CPU_BIT;
        else if (i >= FLOOD_UC_E && i < FLOOD_UC_E + NCLS)
            m = FRONT_ALL;
        else if (i >= SRC_BASE && i < SRC_BASE + NPORT)
            m = FRONT_ALL & ~(pmask_t'(1) << (i - SRC_BASE));
        return m;
    endfunction

    function automatic logic is_storage(int unsigned i);
        return (i < RSV_FIRST) || (i >= SRC_BASE && i < TBL_DEPTH);
    endfunction

endpackage

// File: rtl/pgr_mask_table.sv
module pgr_mask_table
    import pgr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  tidx_t  wr_addr,
    input  pmask_t wr_data,
    input  tidx_t  rd_dst_idx,
    input  tidx_t  rd_src_idx,
    output pmask_t rd_dst,
    output pmask_t rd_src
);

    pmask_t mem [TBL_DEPTH];

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_entry
        if (is_storage(g)) begin : g_store
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= reset_entry(g);
                else if (wr_en && wr_addr == tidx_t'(g))
                    mem[g] <= wr_data;
            end
        end else begin : g_rsv
            assign mem[g] = '0;
        end
    end

    always_comb begin
        rd_dst = '0;
        rd_src = '0;
        if (int'(rd_dst_idx) < TBL_DEPTH) rd_dst = mem[rd_dst_idx];
        if (int'(rd_src_idx) < TBL_DEPTH) rd_src = mem[rd_src_idx];
    end

endmodule

// File: rtl/pgr_dest_select.sv
module pgr_dest_select
    import pgr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ptr_wr_en,
    input  fclass_t ptr_wr_cls,
    input  tidx_t   ptr_wr_idx,
    input  logic    hit,
    input  tidx_t   dest,
    input  fclass_t cls,
    output tidx_t   dst_idx,
    output logic    dst_ok
);

    tidx_t ptr_q [NCLS];

    for (genvar c = 0; c < NCLS; c++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[c] <= tidx_t'(FLOOD_UC_E + c);
            else if (ptr_wr_en && ptr_wr_cls == fclass_t'(c))
                ptr_q[c] <= ptr_wr_idx;
        end
    end

    always_comb begin
        dst_idx = dest;
        dst_ok  = 1'b0;
        if (hit) begin
            dst_ok = (int'(dest) <= MC_LAST);
        end else begin
            unique case (cls)
                FC_UC:   begin dst_idx = ptr_q[0]; dst_ok = 1'b1; end
                FC_MC:   begin dst_idx = ptr_q[1]; dst_ok = 1'b1; end
                FC_BC:   begin dst_idx = ptr_q[2]; dst_ok = 1'b1; end
                default: dst_ok = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pgr_combine.sv
module pgr_combine
    import pgr_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] etype,
    input  port_t      src,
    input  logic       dst_ok,
    input  pmask_t     dst_mask,
    input  pmask_t     src_mask,
    output verdict_t   verdict
);

    pmask_t dm, sm, fwd;
    logic   src_front;
    logic   copy;

    always_comb begin
        src_front = (int'(src) < NPORT);
        dm        = dst_ok ? dst_mask : '0;
        sm        = src_front ? src_mask : '0;
        fwd       = dm & AGG_ALL & sm;
        if (src_front)
            fwd = fwd & ~(pmask_t'(1) << src);
        copy      = hit && (etype < 2'd2) && dm[CPU_BIT];
        verdict.egress   = fwd | (pmask_t'(copy) << CPU_BIT);
        verdict.cpu_copy = copy;
    end

endmodule

// File: rtl/pgroup_fwd_resolver.sv
module pgroup_fwd_resolver
    import pgr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tbl_wr_en,
    input  logic [6:0]  tbl_wr_addr,
    input  logic [12:0] tbl_wr_data,
    input  logic        ptr_wr_en,
    input  logic [1:0]  ptr_wr_cls,
    input  logic [6:0]  ptr_wr_idx,
    input  logic        frm_valid,
    input  logic [3:0]  frm_src_port,
    input  logic        frm_hit,
    input  logic [1:0]  frm_etype,
    input  logic [6:0]  frm_dest_idx,
    input  logic [1:0]  frm_cls,
    output logic        out_valid,
    output logic [12:0] out_egress,
    output logic        out_cpu_copy
);

    frame_t   frm;
    tidx_t    dst_idx;
    tidx_t    src_idx;
    logic     dst_ok;
    pmask_t   dst_mask, src_mask;
    verdict_t verdict, verdict_q;
    logic     valid_q;

    assign frm.hit   = frm_hit;
    assign frm.etype = frm_etype;
    assign frm.dest  = frm_dest_idx;
    assign frm.cls   = fclass_t'(frm_cls);
    assign frm.src   = frm_src_port;

    assign src_idx = tidx_t'(SRC_BASE) + tidx_t'(frm.src);

    pgr_dest_select u_dsel (
        .clk        (clk),
        .rst        (rst),
        .ptr_wr_en  (ptr_wr_en),
        .ptr_wr_cls (fclass_t'(ptr_wr_cls)),
        .ptr_wr_idx (ptr_wr_idx),
        .hit        (frm.hit),
        .dest       (frm.dest),
        .cls        (frm.cls),
        .dst_idx    (dst_idx),
        .dst_ok     (dst_ok)
    );

    pgr_mask_table u_tbl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_wr_en),
        .wr_addr    (tbl_wr_addr),
        .wr_data    (tbl_wr_data),
        .rd_dst_idx (dst_idx),
        .rd_src_idx (src_idx),
        .rd_dst     (dst_mask),
        .rd_src     (src_mask)
    );

    pgr_combine u_comb (
        .hit      (frm.hit),
        .etype    (frm.etype),
        .src      (frm.src),
        .dst_ok   (dst_ok),
        .dst_mask (dst_mask),
        .src_mask (src_mask),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q   <= frm_valid;
            verdict_q <= frm_valid ? verdict : '0;
        end
    end

    assign out_valid    = valid_q;
    assign out_egress   = verdict_q.egress;
    assign out_cpu_copy = verdict_q.cpu_copy;

endmodule

// File: rtl/pgr_checker.sv
module pgr_checker
    import pgr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frm_valid,
    input logic [3:0]  frm_src_port,
    input logic        frm_hit,
    input logic [1:0]  frm_etype,
    input logic        out_valid,
    input logic [12:0] out_egress,
    input logic        out_cpu_copy
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> out_valid);

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_egress == '0 && !out_cpu_copy));

    // R7
    copy_sets_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        out_cpu_copy |-> out_egress[CPU_BIT]);

    // R8
    copy_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !(frm_hit && frm_etype < 2'd2)) |=> !out_cpu_copy);

    // R6
    own_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && int'(frm_src_port) < NPORT) |=>
            ((out_egress & (13'(1) << $past(frm_src_port))) == '0));

endmodule

bind pgroup_fwd_resolver pgr_checker u_pgr_checker (
    .clk          (clk),
    .rst          (rst),
    .frm_valid    (frm_valid),
    .frm_src_port (frm_src_port),
    .frm_hit      (frm_hit),
    .frm_etype    (frm_etype),
    .out_valid    (out_valid),
    .out_egress   (out_egress),
    .out_cpu_copy (out_cpu_copy)
);

// File: tb/pgroup_fwd_resolver_bench.sv
module pgroup_fwd_resolver_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        tbl_wr_en;
    logic [6:0]  tbl_wr_addr;
    logic [12:0] tbl_wr_data;
    logic        ptr_wr_en;
    logic [1:0]  ptr_wr_cls;
    logic [6:0]  ptr_wr_idx;
    logic        frm_valid;
    logic [3:0]  frm_src_port;
    logic        frm_hit;
    logic [1:0]  frm_etype;
    logic [6:0]  frm_dest_idx;
    logic [1:0]  frm_cls;
    logic        out_valid;
    logic [12:0] out_egress;
    logic        out_cpu_copy;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;
    string       tag_override = "";

    logic [12:0] sh_tbl [92];
    logic [6:0]  sh_ptr [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgroup_fwd_resolver u_pgroup_fwd_resolver (
        .clk(clk), .rst(rst),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_cls(ptr_wr_cls), .ptr_wr_idx(ptr_wr_idx),
        .frm_valid(frm_valid), .frm_src_port(frm_src_port), .frm_hit(frm_hit),
        .frm_etype(frm_etype), .frm_dest_idx(frm_dest_idx), .frm_cls(frm_cls),
        .out_valid(out_valid), .out_egress(out_egress), .out_cpu_copy(out_cpu_copy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit storage_addr(int a);
        return (a < 64) || (a >= 80 && a < 92);
    endfunction

    // R9 reset image, derived from the requirement text
    task automatic shadow_reset();
        for (int i = 0; i < 92; i++) begin
            sh_tbl[i] = 13'h0;
            if (i < 12) sh_tbl[i] = 13'(1) << i;
            if (i == 59) sh_tbl[i] = 13'h1000;
            if (i >= 60 && i <= 62) sh_tbl[i] = 13'h0FFF;
            if (i >= 80) sh_tbl[i] = 13'h0FFF & ~(13'(1) << (i - 80));
        end
        sh_ptr[0] = 7'd60; sh_ptr[1] = 7'd61; sh_ptr[2] = 7'd62;
    endtask

    function automatic logic [13:0] expect_v(int s, bit h, int et, int d, int c);
        logic [12:0] dm, sm, fwd;
        bit cp;
        dm = 13'h0;
        if (h) begin
            if (d < 64) dm = sh_tbl[d];
        end else if (c < 3) begin
            if (int'(sh_ptr[c]) < 92) dm = sh_tbl[sh_ptr[c]];
        end
        sm  = (s < 12) ? sh_tbl[80 + s] : 13'h0;
        fwd = dm & sm;
        if (s < 12) fwd[s] = 1'b0;
        cp  = h && (et < 2) && dm[12];
        if (cp) fwd[12] = 1'b1;
        return {fwd, cp};
    endfunction

    function automatic string tag_for(int s, bit h, int et, int d, int c);
        if (tag_override != "") return tag_override;
        if (s >= 12) return "R5";
        if (h && et < 2 && d < 64 && sh_tbl[d][12]) return "R7";
        if (h && d >= 64) return "R3";
        if (h) return (et >= 2) ? "R8" : "R2";
        if (c == 3) return "R4";
        return "R4";
    endfunction

    task automatic drive(int s, bit h, int et, int d, int c);
        frm_valid    = 1'b1;
        frm_src_port = 4'(s);
        frm_hit      = h;
        frm_etype    = 2'(et);
        frm_dest_idx = 7'(d);
        frm_cls      = 2'(c);
    endtask

    task automatic check_out(int s, logic [13:0] e, string t);
        chk("R1", 32'(out_valid), 32'd1);
        chk(t, 32'(out_egress), 32'(e[13:1]));
        chk((e[0] ? "R7" : "R8"), 32'(out_cpu_copy), 32'(e[0]));
        if (s < 12) chk("R6", 32'(out_egress[s]), 32'd0);
    endtask

    task automatic run_frame(int s, bit h, int et, int d, int c);
        logic [13:0] e;
        string t;
        @(negedge clk);
        chk("R12", {18'h0, out_valid, out_egress}, 32'd0);
        e = expect_v(s, h, et, d, c);
        t = tag_for(s, h, et, d, c);
        drive(s, h, et, d, c);
        @(negedge clk);
        frm_valid = 1'b0;
        check_out(s, e, t);
    endtask

    task automatic tbl_write(int a, logic [12:0] v);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = 7'(a); tbl_wr_data = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (storage_addr(a)) sh_tbl[a] = v;
    endtask

    task automatic ptr_write(int c, int idx);
        @(negedge clk);
        ptr_wr_en = 1'b1; ptr_wr_cls = 2'(c); ptr_wr_idx = 7'(idx);
        @(negedge clk);
        ptr_wr_en = 1'b0;
        if (c < 3) sh_ptr[c] = 7'(idx);
    endtask

    task automatic sweep(int n_dest);
        int dl [8] = '{0, 5, 11, 12, 59, 63, 64, 90};
        for (int s = 0; s < 13; s++)
            for (int k = 0; k < n_dest; k++)
                for (int m = 0; m < 8; m++)
                    run_frame(s, m < 4, m % 4, dl[k], m % 4);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [13:0] e;
        rst = 1'b1;
        tbl_wr_en = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
        ptr_wr_en = 0; ptr_wr_cls = 0; ptr_wr_idx = 0;
        frm_valid = 0; frm_src_port = 0; frm_hit = 0;
        frm_etype = 0; frm_dest_idx = 0; frm_cls = 0;
        shadow_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset contents observed through frames
        tag_override = "R9";
        sweep(5);
        tag_override = "";

        // R10: write every address including reserved and out-of-range ones
        for (int a = 0; a < 100; a++)
            tbl_write(a, 13'(a * 613) ^ 13'(a * a * 29) ^ 13'h0A5A);
        tbl_write(59, 13'h1000);

        // R11: retarget flood pointers; class 3 write must be ignored
        ptr_write(0, 70);
        ptr_write(1, 59);
        ptr_write(2, 85);
        ptr_write(3, 0);
        sweep(8);

        ptr_write(0, 12);
        ptr_write(1, 95);
        ptr_write(2, 3);
        sweep(4);

        // R10: reserved entry behind unicast pointer must read empty
        ptr_write(0, 70);
        run_frame(1, 0, 0, 0, 0);
        chk("R10", 32'(out_egress), 32'd0);

        // R11: table write and frame in the same cycle use the old entry
        tbl_write(81, 13'h1FFF);
        @(negedge clk);
        e = expect_v(1, 1, 0, 59, 0);
        drive(1, 1, 0, 59, 0);
        tbl_wr_en = 1'b1; tbl_wr_addr = 7'd59; tbl_wr_data = 13'h0004;
        @(negedge clk);
        frm_valid = 1'b0; tbl_wr_en = 1'b0;
        sh_tbl[59] = 13'h0004;
        check_out(1, e, "R11");
        run_frame(1, 1, 0, 59, 0);

        // R11: pointer write and frame in the same cycle
        @(negedge clk);
        e = expect_v(1, 0, 0, 0, 2);
        drive(1, 0, 0, 0, 2);
        ptr_wr_en = 1'b1; ptr_wr_cls = 2'd2; ptr_wr_idx = 7'd61;
        @(negedge clk);
        frm_valid = 1'b0; ptr_wr_en = 1'b0;
        sh_ptr[2] = 7'd61;
        check_out(1, e, "R11");
        run_frame(1, 0, 0, 0, 2);

        // R7 versus R8: CPU in destination, excluded by source group
        tbl_write(82, 13'h0FFB);
        tbl_write(40, 13'h1003);
        ptr_write(0, 40);
        run_frame(2, 1, 1, 40, 0);
        chk("R7", 32'(out_cpu_copy), 32'd1);
        run_frame(2, 0, 0, 40, 0);
        chk("R8", 32'(out_egress[12]), 32'd0);
        run_frame(2, 1, 3, 40, 0);
        chk("R8", 32'(out_cpu_copy), 32'd0);

        @(negedge clk);
        chk("R12", {18'h0, out_valid, out_egress}, 32'd0);
        finish_run();
    end

endmodule